// File: doc/BRIEF.md
# Predicate Evaluator and Status Flag Register

This block keeps the four arithmetic status flags of a processor pipeline (negative, zero, carry, overflow) and decides, for each instruction that reaches it, whether that instruction may take effect. Every instruction carries a 4-bit predicate field. The block tests that field against the flags it currently holds. It reports the verdict one clock later on a registered execute-enable output. In the same clock edge it writes the flags from the ALU result, if the instruction is allowed to do so.

The flags change only for an instruction that passes its predicate and that either asks for a flag update or belongs to the compare class. Compare-class operations write the flags every time they execute. An instruction whose predicate fails leaves the flags untouched, even when it is a compare. This lets a chain of conditional compares build up a compound test. For logical operations, the carry comes from the shifter and the overflow flag is kept. The ALU and instruction fetch sit outside this block.

Top module: `cond_flag_unit`

## Requirements
- R1: During and after a synchronous active-high reset, `flags_o` is 4'b0000 and `exec_o` is 0 until the first valid instruction is registered.
- R2: `exec_o` in the cycle after a valid instruction is 1 exactly when its predicate holds on the flags held before that edge. `flags_o` is {N,Z,C,V} with N in bit 3 and V in bit 0. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always.
- R3: Predicate code 15 never executes. `exec_o` is 0 after it, and the flags are not written.
- R4: A cycle with `valid_i` low gives `exec_o` = 0 on the next cycle and leaves `flags_o` unchanged.
- R5: An instruction whose predicate fails does not change `flags_o`, even when it is a compare with `set_flags_i` high.
- R6: An executing non-compare instruction with `set_flags_i` low does not change `flags_o`.
- R7: An executing compare-class instruction (`is_compare_i` = 1) writes `flags_o` from the ALU flags one cycle later, whatever the value of `set_flags_i`.
- R8: An executing flag-writing instruction with `is_logical_i` = 1 loads N, Z and C from the ALU inputs (C being the shifter carry) and keeps V.
- R9: An executing instruction with `set_flags_i` high and `is_logical_i` low loads all four flags from the ALU inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| cond_i | input | 4 | Predicate code of the instruction |
| set_flags_i | input | 1 | Instruction asks for a flag update |
| is_compare_i | input | 1 | Compare-class instruction (always writes the flags when it executes) |
| is_logical_i | input | 1 | Logical operation: the overflow flag is kept |
| alu_n_i | input | 1 | ALU result negative |
| alu_z_i | input | 1 | ALU result zero |
| alu_c_i | input | 1 | ALU carry out or shifter carry |
| alu_v_i | input | 1 | ALU signed overflow |
| exec_o | output | 1 | Registered execute-enable for the previous cycle's instruction |
| flags_o | output | 4 | Held flags {N,Z,C,V} |

## Verification
The bench loads each of the sixteen flag combinations and, for each, tries every predicate code. This catches a swapped signed/unsigned relation, or a code 15 that is treated as always. It then issues a compare whose predicate fails. A design that gated the write only on the compare bit would corrupt the flags there. Further cases cover an executing data operation without the set-flags bit and a logical operation with distinct ALU overflow. A design that wrote all four flags unconditionally, or that cleared V on logical operations, would show a wrong `flags_o` one cycle later.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [COND_W-1:0] {
    C_ZSET  = 4'd0,  C_ZCLR  = 4'd1,  C_CSET  = 4'd2,  C_CCLR = 4'd3,
    C_NSET  = 4'd4,  C_NCLR  = 4'd5,  C_VSET  = 4'd6,  C_VCLR = 4'd7,
    C_UGT   = 4'd8,  C_ULE   = 4'd9,  C_SGE   = 4'd10, C_SLT  = 4'd11,
    C_SGT   = 4'd12, C_SLE   = 4'd13, C_ALWAYS = 4'd14, C_NEVER = 4'd15
  } pred_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cond_check.sv
module cond_check
  import cond_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              pass_o
);
  logic signed_ge;
  assign signed_ge = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (pred_e'(cond_i))
      C_ZSET:   pass_o = flags_i.z;
      C_ZCLR:   pass_o = !flags_i.z;
      C_CSET:   pass_o = flags_i.c;
      C_CCLR:   pass_o = !flags_i.c;
      C_NSET:   pass_o = flags_i.n;
      C_NCLR:   pass_o = !flags_i.n;
      C_VSET:   pass_o = flags_i.v;
      C_VCLR:   pass_o = !flags_i.v;
      C_UGT:    pass_o = flags_i.c && !flags_i.z;
      C_ULE:    pass_o = !flags_i.c || flags_i.z;
      C_SGE:    pass_o = signed_ge;
      C_SLT:    pass_o = !signed_ge;
      C_SGT:    pass_o = !flags_i.z && signed_ge;
      C_SLE:    pass_o = flags_i.z || !signed_ge;
      C_ALWAYS: pass_o = 1'b1;
      default:  pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_next.sv
module flag_next
  import cond_pkg::*;
#(
  parameter bit KEEP_V_LOGICAL = 1'b1
)(
  input  flags_t cur_i,
  input  flags_t alu_i,
  input  logic   logical_i,
  output flags_t nxt_o
);
  assign nxt_o.n = alu_i.n;
  assign nxt_o.z = alu_i.z;
  assign nxt_o.c = alu_i.c;

  generate
    if (KEEP_V_LOGICAL) begin : g_keep_v
      assign nxt_o.v = logical_i ? cur_i.v : alu_i.v;
    end else begin : g_write_v
      logic unused_logical;
      assign unused_logical = logical_i;
      assign nxt_o.v = alu_i.v;
    end
  endgenerate
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cond_pkg::*;
#(
  parameter bit KEEP_V_LOGICAL = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              set_flags_i,
  input  logic              is_compare_i,
  input  logic              is_logical_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  input  logic              alu_c_i,
  input  logic              alu_v_i,
  output logic              exec_o,
  output logic [FLAG_W-1:0] flags_o
);
  flags_t flags_q, flags_nxt, alu_f;
  logic   pass, fire, wr_flags;

  assign alu_f = '{n: alu_n_i, z: alu_z_i, c: alu_c_i, v: alu_v_i};

  cond_check u_check (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (pass)
  );

  flag_next #(.KEEP_V_LOGICAL(KEEP_V_LOGICAL)) u_next (
    .cur_i     (flags_q),
    .alu_i     (alu_f),
    .logical_i (is_logical_i),
    .nxt_o     (flags_nxt)
  );

  assign fire     = valid_i && pass;
  assign wr_flags = fire && (set_flags_i || is_compare_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      exec_o  <= 1'b0;
    end else begin
      exec_o <= fire;
      if (wr_flags) flags_q <= flags_nxt;
    end
  end

  assign flags_o = flags_q;

  assert_reset_R1: assert property (@(posedge clk) rst |=> (flags_o == '0 && !exec_o));
  assert_never_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cond_i == 4'd15) |=> (!exec_o && $stable(flags_o)));
  assert_always_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cond_i == 4'd14) |=> exec_o);
  assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!exec_o && $stable(flags_o)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !pass) |=> $stable(flags_o));
  assert_noset_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !set_flags_i && !is_compare_i) |=> $stable(flags_o));
  assert_cmp_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && is_compare_i && !is_logical_i) |=>
      flags_o == $past({alu_n_i, alu_z_i, alu_c_i, alu_v_i}));
  assert_keepv_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_flags && is_logical_i) |=> flags_o[0] == $past(flags_o[0]));
endmodule

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
  typedef struct {
    logic       ex;
    logic [3:0] fl;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic valid_i = 0, set_flags_i = 0, is_compare_i = 0, is_logical_i = 0;
  logic [3:0] cond_i = 0;
  logic alu_n_i = 0, alu_z_i = 0, alu_c_i = 0, alu_v_i = 0;
  logic exec_o;
  logic [3:0] flags_o;

  int n_run = 0, n_fail = 0;
  exp_t q[$];
  logic [3:0] mflags = 4'b0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_flag_unit i_cond_flag_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i),
    .set_flags_i(set_flags_i), .is_compare_i(is_compare_i),
    .is_logical_i(is_logical_i), .alu_n_i(alu_n_i), .alu_z_i(alu_z_i),
    .alu_c_i(alu_c_i), .alu_v_i(alu_v_i), .exec_o(exec_o), .flags_o(flags_o)
  );

  function automatic logic holds(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy && !z;     9: return !cy || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic vld, input logic [3:0] c, input logic sf,
                       input logic cmp, input logic lg, input logic [3:0] alu,
                       input string tag);
    exp_t e;
    logic ok;
    @(negedge clk);
    valid_i = vld; cond_i = c; set_flags_i = sf; is_compare_i = cmp;
    is_logical_i = lg; {alu_n_i, alu_z_i, alu_c_i, alu_v_i} = alu;
    ok = vld && holds(c, mflags);
    if (ok && (sf || cmp)) mflags = lg ? {alu[3:1], mflags[0]} : alu;
    e.ex = ok; e.fl = mflags; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (exec_o !== e.ex || flags_o !== e.fl) begin
          n_fail++;
          $display("FAIL %s: exec=%0b flags=%b expected exec=%0b flags=%b",
                   e.tag, exec_o, flags_o, e.ex, e.fl);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (flags_o !== 4'b0 || exec_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: exec=%0b flags=%b expected exec=0 flags=0000", exec_o, flags_o);
    end
    @(negedge clk); rst = 0;

    for (int f = 0; f < 16; f++) begin
      drive(1, 4'd14, 0, 1, 0, 4'(f), "R7 compare load");
      for (int c = 0; c < 16; c++)
        drive(1, 4'(c), 0, 0, 0, 4'(~f), (c == 15) ? "R3 never" : "R2 predicate");
    end

    drive(1, 4'd14, 1, 0, 0, 4'b0100, "R9 set flags");        // Z=1
    drive(1, 4'd1, 1, 1, 0, 4'b1011, "R5 failed compare");    // NE fails
    drive(1, 4'd0, 0, 0, 0, 4'b1011, "R6 no set bit");        // EQ passes
    drive(0, 4'd14, 1, 1, 0, 4'b1111, "R4 idle");
    drive(1, 4'd14, 1, 0, 0, 4'b0001, "R9 set V");            // V=1
    drive(1, 4'd14, 1, 0, 1, 4'b1010, "R8 logical keeps V");
    drive(1, 4'd14, 0, 1, 1, 4'b0110, "R8 logical compare");
    drive(1, 4'd15, 1, 1, 0, 4'b1111, "R3 never with compare");
    drive(1, 4'd14, 0, 1, 0, 4'b0000, "R7 compare no set bit");
    drive(0, 4'd0, 0, 0, 0, 4'b0000, "R4 idle tail");

    @(negedge clk); valid_i = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule